// File: doc/BRIEF.md
# I2C Slave EEPROM Controller with Write Inhibit

This block is the two-wire bus slave in front of a 128-byte non-volatile array. It watches already-synchronised SCL and SDA samples for START and STOP conditions, takes in a device select byte, and then either loads a byte address and receives data or streams array bytes back to the master. The block only pulls SDA low and never drives it high, so it can share a wired-AND bus with other devices. Data bytes of a write are collected in an 8-byte row buffer. The array itself is written only after the closing STOP, during a timed program cycle.

While a program cycle runs, the block ignores the bus completely. A master that repeats the write select byte gets no acknowledge until the cycle has ended, which lets it poll for completion. A write-enable level input decides whether a write takes effect at all. When it is low, every byte is still acknowledged, but nothing reaches the array. The block also stays idle until the mode controller asserts the bidirectional-mode enable.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: While `bidir_en` is low, the block never pulls SDA low and never writes the array, whatever happens on the bus. After reset, `sda_oe` and `mem_we` are both low.
- R2: A START is SDA falling while SCL stays high. A STOP is SDA rising while SCL stays high. Bits are taken on SCL rising edges, MSB first. The block changes `sda_oe` only while SCL is low.
- R3: A select byte is accepted when its bits 7:4 are 1010. Bits 3:1 are ignored, and bit 0 selects read (1) or write (0). An accepted select is acknowledged in the ninth clock slot. Any other upper nibble gets no acknowledge.
- R4: In a write, the byte after the select is acknowledged, and its low 7 bits are loaded into the address pointer (bit 7 is ignored). Every data byte that follows is acknowledged as well.
- R5: A byte write followed by STOP, with `wr_en_lvl` high at that STOP, stores the byte at the addressed location.
- R6: Successive data bytes of one write go to successive locations. Only address bits 2:0 advance, so the bytes wrap inside their 8-byte row, and a later byte replaces an earlier one at the same location. Each location is written at most once per program cycle, and all writes of the cycle fall in one row.
- R7: A STOP that ends a valid write starts a program cycle of `PROG_CYCLES` clocks. During the cycle a select byte gets no acknowledge. Once the cycle is over, the block acknowledges again.
- R8: With `wr_en_lvl` low at the STOP, a write is acknowledged on every byte but changes no array location and starts no program cycle.
- R9: A read select returns the byte at the pointer and then advances the pointer. If the master does not acknowledge, the block goes to standby and releases SDA until the next START.
- R10: If the master acknowledges a read byte, the next byte follows, and the pointer wraps from 127 to 0.
- R11: A write select plus an address byte, followed by a repeated START and a read select, returns data starting at that address.
- R12: A START or STOP more than one SCL rising edge into a byte aborts the transfer without a program cycle. So does a STOP after a write that carried no data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bidir_en | input | 1 | Bidirectional mode asserted by the mode controller |
| scl_in | input | 1 | Synchronised SCL level |
| sda_in | input | 1 | Synchronised SDA bus level |
| wr_en_lvl | input | 1 | Write enable level, sampled at the STOP that ends a write |
| sda_oe | output | 1 | Pull SDA low when 1 (open drain) |
| mem_addr | output | 7 | Array address for read and for programming |
| mem_rdata | input | 8 | Array read data for `mem_addr` (combinational) |
| mem_we | output | 1 | Array write strobe |
| mem_wdata | output | 8 | Array write data |

## Verification
Four properties are checked on every cycle:
- The block stays silent while disabled.
- `sda_oe` moves only while SCL is low.
- SDA is never pulled low during a program cycle.
- Consecutive array writes stay within one row.

Other behaviour can only be shown by the bench's bus scenarios: the select-byte decode across all upper nibbles, the wrap of page data inside a row for every starting offset, the length of the program cycle as seen by polling, write inhibit, aborts, and pointer wrap across a full sweep of the array.

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave #(
  parameter int MEM_AW      = 7,
  parameter int ROW_AW      = 3,
  parameter int PROG_CYCLES = 2500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bidir_en,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              wr_en_lvl,
  output logic              sda_oe,
  output logic [MEM_AW-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              mem_we,
  output logic [7:0]        mem_wdata
);
  localparam int ROW = 1 << ROW_AW;
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] ROW_C = CNT_W'(ROW);
  localparam logic [3:0] DEV_ID = 4'b1010;

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_ADDR, S_WR, S_RD, S_PROG} st_t;

  st_t               st;
  logic              scl_q, sda_q;
  logic [3:0]        bitn;
  logic [7:0]        sh;
  logic [MEM_AW-1:0] ptr;
  logic [7:0]        pg_buf [ROW];
  logic [ROW-1:0]    vld;
  logic [CNT_W-1:0]  pcnt;

  wire scl_hi   = scl_in & scl_q;
  wire start_ev = scl_hi & sda_q & ~sda_in;
  wire stop_ev  = scl_hi & ~sda_q & sda_in;
  wire rise     = scl_in & ~scl_q;
  wire fall     = ~scl_in & scl_q;
  wire [ROW_AW-1:0] slot = ptr[ROW_AW-1:0];
  wire [ROW_AW-1:0] pidx = pcnt[ROW_AW-1:0];

  assign mem_addr  = (st == S_PROG) ? {ptr[MEM_AW-1:ROW_AW], pidx} : ptr;
  assign mem_we    = (st == S_PROG) && (pcnt < ROW_C) && vld[pidx];
  assign mem_wdata = pg_buf[pidx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      bitn <= '0;
      sh <= '0;
      ptr <= '0;
      vld <= '0;
      pcnt <= '0;
      sda_oe <= 1'b0;
      for (int i = 0; i < ROW; i++) pg_buf[i] <= '0;
    end else begin
      scl_q <= scl_in;
      sda_q <= sda_in;
      if (!bidir_en) begin
        st <= S_IDLE;
        sda_oe <= 1'b0;
        vld <= '0;
        bitn <= '0;
      end else if (st == S_PROG) begin
        sda_oe <= 1'b0;
        pcnt <= pcnt + 1'b1;
        if (pcnt == LAST) begin
          st <= S_IDLE;
          vld <= '0;
        end
      end else if (start_ev) begin
        st <= S_DEV;
        bitn <= '0;
        sda_oe <= 1'b0;
        vld <= '0;
      end else if (stop_ev) begin
        sda_oe <= 1'b0;
        bitn <= '0;
        if (st == S_WR && bitn <= 4'd1 && |vld && wr_en_lvl) begin
          st <= S_PROG;
          pcnt <= '0;
        end else begin
          st <= S_IDLE;
          vld <= '0;
        end
      end else if (st != S_IDLE) begin
        if (rise) begin
          if (bitn < 4'd8) begin
            if (st != S_RD) sh <= {sh[6:0], sda_in};
            bitn <= bitn + 1'b1;
          end else if (bitn == 4'd8 && st == S_RD) begin
            ptr <= ptr + 1'b1;
            if (sda_in) begin
              st <= S_IDLE;
              bitn <= '0;
            end else begin
              bitn <= 4'd9;
            end
          end
        end else if (fall) begin
          if (bitn == 4'd8 && st != S_RD) begin
            bitn <= 4'd9;
            case (st)
              S_DEV:
                if (sh[7:4] == DEV_ID) begin
                  sda_oe <= 1'b1;
                  st <= sh[0] ? S_RD : S_ADDR;
                end else begin
                  st <= S_IDLE;
                  bitn <= '0;
                end
              S_ADDR: begin
                sda_oe <= 1'b1;
                ptr <= sh[MEM_AW-1:0];
                st <= S_WR;
              end
              S_WR: begin
                sda_oe <= 1'b1;
                pg_buf[slot] <= sh;
                vld[slot] <= 1'b1;
                ptr[ROW_AW-1:0] <= slot + 1'b1;
              end
              default: ;
            endcase
          end else if (bitn == 4'd8) begin
            sda_oe <= 1'b0;
          end else if (bitn == 4'd9) begin
            bitn <= '0;
            if (st == S_RD) begin
              sh <= mem_rdata;
              sda_oe <= ~mem_rdata[7];
            end else begin
              sda_oe <= 1'b0;
            end
          end else if (st == S_RD && bitn != 4'd0) begin
            sda_oe <= ~sh[3'd7 - bitn[2:0]];
          end
        end
      end
    end
  end

  a_r1_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !bidir_en |=> !sda_oe && !mem_we);

  a_r2_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n || !bidir_en)
    !$stable(sda_oe) |-> !scl_in);

  a_r7_deaf_in_prog: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_PROG |-> !sda_oe);

  a_r6_single_row: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && $past(mem_we) |-> mem_addr[MEM_AW-1:ROW_AW] == $past(mem_addr[MEM_AW-1:ROW_AW]));
endmodule

// File: tb/eeprom_i2c_slave_test.sv
module eeprom_i2c_slave_test;
  localparam int PROG = 200;
  localparam int Q = 6;

  logic clk = 1'b0, rst_n = 1'b0, bidir_en = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, vclk = 1'b1;
  logic sda_oe, mem_we;
  logic [6:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] arr [128];
  logic [7:0] model [128];
  wire sda_bus = sda_m & ~sda_oe;
  wire [7:0] mem_rdata = arr[mem_addr];
  int wcount = 0, n_chk = 0, n_bad = 0, edge_bad = 0, cur = 0;
  logic oe_d = 1'b0;
  bit done = 0;

  eeprom_i2c_slave #(.MEM_AW(7), .ROW_AW(3), .PROG_CYCLES(PROG)) uut (
    .clk(clk), .rst_n(rst_n), .bidir_en(bidir_en), .scl_in(scl), .sda_in(sda_bus),
    .wr_en_lvl(vclk), .sda_oe(sda_oe), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_we(mem_we), .mem_wdata(mem_wdata));

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (mem_we) begin
      arr[mem_addr] <= mem_wdata;
      wcount <= wcount + 1;
    end
    oe_d <= sda_oe;
    if (sda_oe !== oe_d && scl && bidir_en) edge_bad <= edge_bad + 1;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic i_start;
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic i_stop;
    sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic bits(input int n, input logic [7:0] b);
    for (int i = 0; i < n; i++) begin
      sda_m = b[7-i]; tick(Q); scl = 1'b1; tick(Q); scl = 1'b0; tick(Q);
    end
  endtask

  task automatic tx(input logic [7:0] b, output bit ack);
    bits(8, b);
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q/2);
    ack = !sda_bus;
    tick(Q - Q/2); scl = 1'b0; tick(Q);
  endtask

  task automatic rx(input bit mack, output logic [7:0] b);
    b = '0;
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(Q); scl = 1'b1; tick(Q/2);
      b = {b[6:0], sda_bus};
      tick(Q - Q/2); scl = 1'b0;
    end
    tick(Q); sda_m = mack ? 1'b0 : 1'b1; tick(Q); scl = 1'b1; tick(Q); scl = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic dev(input logic [7:0] b, output bit ack);
    i_start;
    tx(b, ack);
  endtask

  task automatic poll(output int tries);
    bit a;
    tries = 0;
    for (int t = 0; t < 100; t++) begin
      dev(8'hA0, a);
      i_stop;
      tries++;
      if (a) break;
      tick(20);
    end
  endtask

  task automatic read_at(input int a, input int n, input string tag);
    bit ack;
    logic [7:0] b;
    dev(8'hA0, ack); chk({tag, " R11 select ack"}, ack, 1);
    tx(8'(a), ack);  chk({tag, " R11 address ack"}, ack, 1);
    dev(8'hA1, ack); chk({tag, " R11 read select ack"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      rx(k != n - 1, b);
      chk(tag, b, model[(a + k) % 128]);
    end
    i_stop;
    cur = (a + n) % 128;
  endtask

  initial begin
    bit ack;
    logic [7:0] b;
    int w0, tries;
    for (int i = 0; i < 128; i++) begin
      arr[i] = 8'(i * 7 + 3);
      model[i] = 8'(i * 7 + 3);
    end
    tick(5);
    chk("R1 reset sda_oe", sda_oe, 0);
    chk("R1 reset mem_we", mem_we, 0);
    rst_n = 1'b1;
    tick(3);

    dev(8'hA0, ack); chk("R1 no ack while disabled", ack, 0);
    i_stop;
    chk("R1 no array write while disabled", wcount, 0);
    bidir_en = 1'b1;
    tick(4);

    for (int v = 0; v < 16; v++) begin
      dev({4'(v), 3'(v * 5), 1'b0}, ack);
      chk($sformatf("R3 select nibble %0h", v), ack, (v == 10) ? 1 : 0);
      i_stop;
    end
    for (int x = 0; x < 8; x++) begin
      dev({4'b1010, 3'(x), 1'b0}, ack);
      chk($sformatf("R3 ignored bits %0d", x), ack, 1);
      i_stop;
    end
    chk("R12 no write after select-only stops", wcount, 0);

    read_at(120, 16, "R10 wrap read");
    dev(8'hA1, ack); chk("R3 read select ack", ack, 1);
    rx(1'b0, b); chk("R9 current address read", b, model[cur]);
    rx(1'b0, b); chk("R9 standby releases SDA", b, 8'hFF);
    i_stop;
    dev(8'hA1, ack);
    rx(1'b0, b); chk("R9 pointer advanced once", b, model[(cur + 1) % 128]);
    i_stop;

    w0 = wcount;
    dev(8'hA0, ack);
    tx(8'h85, ack); chk("R4 address ack", ack, 1);
    tx(8'hC3, ack); chk("R4 data ack", ack, 1);
    i_stop;
    model[5] = 8'hC3;
    dev(8'hA0, ack); chk("R7 no ack during program cycle", ack, 0);
    i_stop;
    tick(PROG);
    dev(8'hA0, ack); chk("R7 ack after program cycle", ack, 1);
    i_stop;
    chk("R5 write count", wcount - w0, 1);
    chk("R2 R5 byte stored MSB first", arr[5], 8'hC3);

    for (int s = 0; s < 8; s++) begin
      int row = (s + 2) * 8;
      int n = 3 + s;
      w0 = wcount;
      dev(8'hA0, ack);
      tx(8'(row + s), ack);
      for (int k = 0; k < n; k++) begin
        logic [7:0] d = 8'(s * 16 + k + 1);
        tx(d, ack); chk("R4 page data ack", ack, 1);
        model[row + (s + k) % 8] = d;
      end
      i_stop;
      poll(tries);
      chk("R7 polling needed more than one try", (tries > 1) ? 1 : 0, 1);
      chk($sformatf("R6 writes for offset %0d", s), wcount - w0, (n > 8) ? 8 : n);
      read_at(row, 8, "R6 row readback");
    end

    w0 = wcount;
    vclk = 1'b0;
    dev(8'hA0, ack);
    tx(8'd40, ack); chk("R8 address ack inhibited", ack, 1);
    for (int k = 0; k < 4; k++) begin
      tx(8'hE0 + 8'(k), ack); chk("R8 data ack inhibited", ack, 1);
    end
    i_stop;
    vclk = 1'b1;
    dev(8'hA0, ack); chk("R8 no program cycle", ack, 1);
    i_stop;
    chk("R8 no array write", wcount, w0);
    read_at(40, 4, "R8 row unchanged");

    w0 = wcount;
    dev(8'hA0, ack);
    tx(8'd50, ack);
    tx(8'h11, ack);
    bits(4, 8'h55);
    i_start;
    tx(8'hA0, ack); chk("R12 START mid-byte aborts, no cycle", ack, 1);
    i_stop;
    dev(8'hA0, ack);
    tx(8'd60, ack);
    tx(8'h22, ack);
    bits(3, 8'h00);
    i_stop;
    dev(8'hA0, ack); chk("R12 STOP mid-byte aborts, no cycle", ack, 1);
    tx(8'd62, ack);
    i_stop;
    dev(8'hA0, ack); chk("R12 STOP with no data, no cycle", ack, 1);
    i_stop;
    chk("R12 aborted writes leave array", wcount, w0);

    read_at(3, 130, "R10 full sweep");
    chk("R2 sda_oe stable while SCL high", edge_bad, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule